// File: doc/BRIEF.md
# Multi-Context Thread Arbiter

This block schedules a fixed set of hardware thread contexts that share one execution engine. Each context keeps a program counter, a register of pending signal events and a mask of the events that may wake it. A context moves through three states: sleeping, ready and executing. A sleeping context becomes ready once any pending event matches its wakeup mask. A ready context may start executing only while its enable bit is set. Exactly one context executes at a time. It keeps the engine until it yields or kills itself.

Software reaches every per-context register indirectly. It first writes a context pointer. The program-counter, signal and wakeup-mask addresses then access the selected context. The enable bits act only on the step from ready to executing. Clearing a bit never takes the engine away from the context that holds it. When the engine is free, the next context is chosen round-robin among the contexts that are both ready and enabled. The search starts just after the context that executed last.

The engine pipeline drives the yield and kill strobes. Event sources post bits to a context through a small event port. The arbiter presents the running context's index and program counter on its outputs.

Top module: `ctx_arbiter`

## Requirements
- R1: After reset no context executes (`run_valid` is 0), and the enable, status and ready-vector registers read 0.
- R2: A sleeping context whose signal register and wakeup mask share a set bit enters the ready state on the next clock edge, and its signal register is cleared at that edge. Writing 1 to both registers therefore makes it ready at once.
- R3: A ready context starts executing only while its enable bit is set. Bit i of the enable register (word address 0) gates context i. When the engine is idle, setting the bit starts the context on the clock edge after the write.
- R4: At most one context executes at a time. Once it starts, it keeps running with an unchanged index until a yield or a kill, even if its enable bit is cleared.
- R5: When the engine is idle, the next context to execute is the first ready and enabled context found searching upward, with wraparound, from the index after the last executed context. After reset the search starts at context 0.
- R6: A yield returns the running context to the sleeping state, and `run_valid` drops on that edge. The context keeps its wakeup mask and becomes ready again only once posted events hit that mask.
- R7: A kill returns the running context to the sleeping state and clears its wakeup mask. `run_valid` drops on that edge. When both strobes arrive together, the kill takes precedence.
- R8: The status register (word address 5) has bit 31 set while a context executes, and carries that context's index in bits 2:0. All of its bits are 0 when the engine is idle.
- R9: The context pointer (word address 1) selects which context the program-counter (2), signal (3) and wakeup-mask (4) addresses access. The executing context's program counter appears on `run_pc`.
- R10: An event post ORs `evt_bits` into the signal register of context `evt_ctx`. A CSR write to that same signal register in the same cycle takes precedence over the post.
- R11: Yield and kill strobes that arrive while no context executes have no effect.
- R12: Read data appears on `csr_rdata` one cycle after `csr_re`. The ready vector at word address 6 holds one bit per context. Word address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Register word address |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Registered read data |
| evt_valid | input | 1 | Event post strobe |
| evt_ctx | input | $clog2(N_CTX) | Context that receives the event bits |
| evt_bits | input | EV_W | Event bits to OR into the signal register |
| yield_i | input | 1 | Running context yields |
| kill_i | input | 1 | Running context kills itself |
| run_valid | output | 1 | A context is executing |
| run_ctx | output | $clog2(N_CTX) | Index of the executing context |
| run_pc | output | PC_W | Program counter of the executing context |

## Verification
A corrupted per-context state shows up in one of two ways. A second context can start while one is already running, which shows as a changed `run_ctx` without an intervening yield or kill. Or a ready, enabled context can stay unscheduled, which shows as `run_valid` remaining low one cycle after the engine frees up. Round-robin pointer errors show on the very next grant as a `run_ctx` that differs from the model's pick. Lost or misplaced signal and mask bits show through the indirect readback, and through a ready-vector bit that changes one edge too early or too late.

// File: rtl/ctxarb_pkg.sv
package ctxarb_pkg;
  typedef enum logic [1:0] {
    CS_SLEEP = 2'd0,
    CS_READY = 2'd1,
    CS_EXEC  = 2'd2
  } ctx_state_e;

  localparam int unsigned A_ENABLE = 0;
  localparam int unsigned A_PTR    = 1;
  localparam int unsigned A_PC     = 2;
  localparam int unsigned A_SIG    = 3;
  localparam int unsigned A_WAKE   = 4;
  localparam int unsigned A_STATUS = 5;
  localparam int unsigned A_READY  = 6;
endpackage

// File: rtl/ctxarb_slot.sv
module ctxarb_slot
  import ctxarb_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int EV_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_pc,
  input  logic            wr_sig,
  input  logic            wr_wake,
  input  logic [PC_W-1:0] pc_wdata,
  input  logic [EV_W-1:0] ev_wdata,
  input  logic            ev_hit,
  input  logic [EV_W-1:0] ev_bits,
  input  logic            grant,
  input  logic            yield_i,
  input  logic            kill_i,
  output ctx_state_e      state,
  output logic [PC_W-1:0] pc,
  output logic [EV_W-1:0] sig,
  output logic [EV_W-1:0] wake
);
  ctx_state_e      st_n;
  logic [EV_W-1:0] sig_n;
  logic [EV_W-1:0] wake_n;
  logic [PC_W-1:0] pc_n;

  always_comb begin
    st_n   = state;
    sig_n  = sig;
    wake_n = wake;
    pc_n   = pc;
    unique case (state)
      CS_SLEEP: begin
        if (|(sig & wake)) begin
          st_n  = CS_READY;
          sig_n = '0;
        end
      end
      CS_READY: begin
        if (grant) st_n = CS_EXEC;
      end
      CS_EXEC: begin
        if (kill_i) begin
          st_n   = CS_SLEEP;
          wake_n = '0;
        end else if (yield_i) begin
          st_n = CS_SLEEP;
        end
      end
      default: st_n = CS_SLEEP;
    endcase
    if (ev_hit)  sig_n  = sig_n | ev_bits;
    if (wr_sig)  sig_n  = ev_wdata;
    if (wr_wake) wake_n = ev_wdata;
    if (wr_pc)   pc_n   = pc_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CS_SLEEP;
      pc    <= '0;
      sig   <= '0;
      wake  <= '0;
    end else begin
      state <= st_n;
      pc    <= pc_n;
      sig   <= sig_n;
      wake  <= wake_n;
    end
  end
endmodule

// File: rtl/ctxarb_rr.sv
module ctxarb_rr #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic             hit,
  output logic [IDX_W-1:0] pick
);
  always_comb begin
    hit  = 1'b0;
    pick = last;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!hit && req[j]) begin
        hit  = 1'b1;
        pick = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/ctx_arbiter.sv
module ctx_arbiter
  import ctxarb_pkg::*;
#(
  parameter int N_CTX  = 8,
  parameter int PC_W   = 12,
  parameter int EV_W   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     csr_we,
  input  logic                     csr_re,
  input  logic [ADDR_W-1:0]        csr_addr,
  input  logic [DATA_W-1:0]        csr_wdata,
  output logic [DATA_W-1:0]        csr_rdata,
  input  logic                     evt_valid,
  input  logic [$clog2(N_CTX)-1:0] evt_ctx,
  input  logic [EV_W-1:0]          evt_bits,
  input  logic                     yield_i,
  input  logic                     kill_i,
  output logic                     run_valid,
  output logic [$clog2(N_CTX)-1:0] run_ctx,
  output logic [PC_W-1:0]          run_pc
);
  localparam int IDX_W = $clog2(N_CTX);

  logic [N_CTX-1:0] en_q;
  logic [IDX_W-1:0] ptr_q;
  logic             busy_q;
  logic [IDX_W-1:0] cur_q;

  ctx_state_e       st_a   [N_CTX];
  logic [PC_W-1:0]  pc_a   [N_CTX];
  logic [EV_W-1:0]  sig_a  [N_CTX];
  logic [EV_W-1:0]  wake_a [N_CTX];
  logic [N_CTX-1:0] ready_vec;
  logic [N_CTX-1:0] exec_vec;
  logic [N_CTX-1:0] grant_vec;

  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;

  wire wr_any = csr_we;

  generate
    for (genvar i = 0; i < N_CTX; i++) begin : g_slot
      wire sel_me = (ptr_q == IDX_W'(i));
      ctxarb_slot #(.PC_W(PC_W), .EV_W(EV_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .wr_pc    (wr_any && sel_me && csr_addr == ADDR_W'(A_PC)),
        .wr_sig   (wr_any && sel_me && csr_addr == ADDR_W'(A_SIG)),
        .wr_wake  (wr_any && sel_me && csr_addr == ADDR_W'(A_WAKE)),
        .pc_wdata (csr_wdata[PC_W-1:0]),
        .ev_wdata (csr_wdata[EV_W-1:0]),
        .ev_hit   (evt_valid && evt_ctx == IDX_W'(i)),
        .ev_bits  (evt_bits),
        .grant    (grant_vec[i]),
        .yield_i  (yield_i),
        .kill_i   (kill_i),
        .state    (st_a[i]),
        .pc       (pc_a[i]),
        .sig      (sig_a[i]),
        .wake     (wake_a[i])
      );
      assign ready_vec[i] = (st_a[i] == CS_READY);
      assign exec_vec[i]  = (st_a[i] == CS_EXEC);
      assign grant_vec[i] = !busy_q && pick_hit && (pick_idx == IDX_W'(i));
    end
  endgenerate

  ctxarb_rr #(.N(N_CTX), .IDX_W(IDX_W)) u_rr (
    .req  (ready_vec & en_q),
    .last (cur_q),
    .hit  (pick_hit),
    .pick (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ptr_q <= '0;
    end else if (csr_we) begin
      if (csr_addr == ADDR_W'(A_ENABLE)) en_q  <= csr_wdata[N_CTX-1:0];
      if (csr_addr == ADDR_W'(A_PTR))    ptr_q <= csr_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cur_q  <= IDX_W'(N_CTX - 1);
    end else if (busy_q) begin
      if (yield_i || kill_i) busy_q <= 1'b0;
    end else if (pick_hit) begin
      busy_q <= 1'b1;
      cur_q  <= pick_idx;
    end
  end

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (int'(csr_addr))
      A_ENABLE: rd_val[N_CTX-1:0] = en_q;
      A_PTR:    rd_val[IDX_W-1:0] = ptr_q;
      A_PC:     rd_val[PC_W-1:0]  = pc_a[ptr_q];
      A_SIG:    rd_val[EV_W-1:0]  = sig_a[ptr_q];
      A_WAKE:   rd_val[EV_W-1:0]  = wake_a[ptr_q];
      A_STATUS: begin
        rd_val[DATA_W-1]  = busy_q;
        rd_val[IDX_W-1:0] = busy_q ? cur_q : '0;
      end
      A_READY:  rd_val[N_CTX-1:0] = ready_vec;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= csr_re ? rd_val : '0;
  end

  assign run_valid = busy_q;
  assign run_ctx   = cur_q;
  assign run_pc    = pc_a[cur_q];
endmodule

// File: rtl/ctx_arbiter_chk.sv
module ctx_arbiter_chk #(
  parameter int N_CTX = 8,
  parameter int IDX_W = $clog2(N_CTX)
) (
  input logic             clk,
  input logic             rst,
  input logic             run_valid,
  input logic [IDX_W-1:0] run_ctx,
  input logic             yield_i,
  input logic             kill_i,
  input logic [N_CTX-1:0] en_q,
  input logic [N_CTX-1:0] exec_vec
);
  p_single_exec_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(exec_vec));

  p_busy_tracks_slots_r8: assert property (@(posedge clk) disable iff (rst)
    run_valid == (|exec_vec));

  p_no_preempt_r4: assert property (@(posedge clk) disable iff (rst)
    (run_valid && !yield_i && !kill_i) |=> (run_valid && $stable(run_ctx)));

  p_start_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(run_valid) |-> |($past(en_q) & (N_CTX'(1) << run_ctx)));

  p_kill_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (run_valid && kill_i) |=> !run_valid);

  p_yield_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (run_valid && yield_i) |=> !run_valid);
endmodule

bind ctx_arbiter ctx_arbiter_chk #(.N_CTX(N_CTX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_valid (run_valid),
  .run_ctx   (run_ctx),
  .yield_i   (yield_i),
  .kill_i    (kill_i),
  .en_q      (en_q),
  .exec_vec  (exec_vec)
);

// File: tb/tb_ctx_arbiter.sv
module tb_ctx_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_ctx = '0;
  logic [7:0]  evt_bits = '0;
  logic        yield_i = 1'b0, kill_i = 1'b0;
  logic        run_valid;
  logic [2:0]  run_ctx;
  logic [11:0] run_pc;

  int total = 0;
  int fails = 0;
  int last_m;
  logic [31:0] rv;

  always #10 clk = ~clk;

  ctx_arbiter dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .evt_valid(evt_valid),
    .evt_ctx(evt_ctx), .evt_bits(evt_bits), .yield_i(yield_i), .kill_i(kill_i),
    .run_valid(run_valid), .run_ctx(run_ctx), .run_pc(run_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 3'(a); csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    csr_re = 1'b1; csr_addr = 3'(a);
    @(negedge clk);
    csr_re = 1'b0;
    d = csr_rdata;
  endtask

  task automatic pulse(input bit do_kill);
    @(negedge clk);
    if (do_kill) kill_i = 1'b1; else yield_i = 1'b1;
    @(negedge clk);
    kill_i = 1'b0; yield_i = 1'b0;
  endtask

  task automatic post(input int c, input logic [7:0] b);
    @(negedge clk);
    evt_valid = 1'b1; evt_ctx = 3'(c); evt_bits = b;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  function automatic int rr_pick(input logic [7:0] set, input int last);
    for (int k = 1; k <= 8; k++) begin
      if (set[(last + k) % 8]) return (last + k) % 8;
    end
    return -1;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 run_valid", {31'd0, run_valid}, 32'd0);
    rd(5, rv); chk("R1 status", rv, 32'd0);
    rd(0, rv); chk("R1 enables", rv, 32'd0);
    rd(6, rv); chk("R1 ready", rv, 32'd0);
    rd(7, rv); chk("R12 reserved", rv, 32'd0);

    // R9 indirect access
    wr(1, 2); wr(2, 32'h123);
    wr(1, 5); wr(2, 32'h055);
    wr(1, 2); rd(2, rv); chk("R9 pc ctx2", rv, 32'h123);
    wr(1, 5); rd(2, rv); chk("R9 pc ctx5", rv, 32'h055);

    // R2 wake on sig&wake
    wr(1, 2); wr(3, 1); wr(4, 1);
    rd(6, rv); chk("R2 ready", rv, 32'h04);
    rd(3, rv); chk("R2 sig cleared", rv, 32'd0);
    chk("R3 not enabled", {31'd0, run_valid}, 32'd0);

    // R3 enable starts next edge
    wr(0, 32'h04);
    chk("R3 same edge idle", {31'd0, run_valid}, 32'd0);
    @(negedge clk);
    chk("R3 started", {31'd0, run_valid}, 32'd1);
    chk("R3 ctx", {29'd0, run_ctx}, 32'd2);
    chk("R9 run_pc", {20'd0, run_pc}, 32'h123);
    rd(5, rv); chk("R8 status busy", rv, 32'h8000_0002);

    // R4 no preemption on enable clear
    wr(0, 0);
    repeat (5) @(negedge clk);
    chk("R4 still running", {31'd0, run_valid}, 32'd1);
    chk("R4 same ctx", {29'd0, run_ctx}, 32'd2);

    // R6 yield
    pulse(1'b0);
    chk("R6 stopped", {31'd0, run_valid}, 32'd0);
    rd(5, rv); chk("R8 status idle", rv, 32'd0);
    post(2, 8'h02);
    repeat (2) @(negedge clk);
    rd(6, rv); chk("R6 no wake on miss", rv, 32'd0);
    rd(3, rv); chk("R10 sig or", rv, 32'h02);
    post(2, 8'h01);
    @(negedge clk);
    rd(6, rv); chk("R6 wake on hit", rv, 32'h04);
    rd(4, rv); chk("R6 mask kept", rv, 32'h01);

    // R10 write beats post in same cycle
    wr(1, 5);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 3'd3; csr_wdata = 32'h40;
    evt_valid = 1'b1; evt_ctx = 3'd5; evt_bits = 8'h01;
    @(negedge clk);
    csr_we = 1'b0; evt_valid = 1'b0;
    rd(3, rv); chk("R10 write wins", rv, 32'h40);
    post(5, 8'h08);
    rd(3, rv); chk("R10 or after", rv, 32'h48);

    // R11 strobes while idle
    pulse(1'b1); pulse(1'b0);
    rd(6, rv); chk("R11 ready kept", rv, 32'h04);
    wr(1, 2); rd(4, rv); chk("R11 mask kept", rv, 32'h01);

    // R7 kill
    wr(0, 32'h04);
    @(negedge clk);
    chk("R7 running", {31'd0, run_valid}, 32'd1);
    pulse(1'b1);
    chk("R7 stopped", {31'd0, run_valid}, 32'd0);
    rd(4, rv); chk("R7 mask cleared", rv, 32'd0);
    rd(5, rv); chk("R7 status", rv, 32'd0);
    wr(0, 0);
    last_m = 2;

    // R5 round robin, random sets
    for (int it = 0; it < 30; it++) begin
      logic [7:0] set;
      set = 8'($urandom);
      if (it == 0) set = 8'h00;
      if (it == 1) set = 8'hFF;
      if (it == 2) set = 8'h01;
      for (int c = 0; c < 8; c++) begin
        if (set[c]) begin
          wr(1, c); wr(4, 1); wr(3, 1);
        end
      end
      repeat (2) @(negedge clk);
      rd(6, rv); chk("R2 armed set", rv, {24'd0, set});
      wr(0, 32'hFF);
      while (set != 0) begin
        int exp_c;
        int waited;
        exp_c = rr_pick(set, last_m);
        waited = 0;
        while (!run_valid && waited < 6) begin
          @(negedge clk);
          waited++;
        end
        chk("R5 rr running", {31'd0, run_valid}, 32'd1);
        chk("R5 rr pick", {29'd0, run_ctx}, 32'(exp_c));
        set[exp_c] = 1'b0;
        last_m = exp_c;
        pulse(1'($urandom));
      end
      repeat (2) @(negedge clk);
      chk("R5 idle after set", {31'd0, run_valid}, 32'd0);
      wr(0, 0);
    end
    report();
  end
endmodule